// File: doc/BRIEF.md
# USB Endpoint Status and Interrupt Register

This block keeps the run-time status of one data endpoint of a USB device function and raises transfer-level interrupts toward the CPU. The protocol engine sends it single-cycle event strobes. These report a completed packet (with its byte count and a zero-length flag), a STALL handshake returned to the host, and decoded endpoint-halt set and clear feature requests. Configuration inputs give the endpoint's direction, its presence in the active configuration and its maximum packet size.

The block presents a 16-bit status word. The upper three bits are read-only state: halted, direction and present. Four interrupt flags in the middle are cleared by writing 1. The block finds the end of a transfer in two ways: a packet shorter than the maximum size, or the first zero-length packet that follows full-size packets. While the end-of-transfer flag of an OUT endpoint is pending, the block asks the protocol engine to answer every host packet with NAK. The interrupt request line is the OR of the flags, each gated by its own enable bit.

Top module: `usb_ep_status`

## Requirements
- R1: After a synchronous reset the status word reads 16'h0000, and `irq` and `nak_force` are 0.
- R2: A `stall_sent` or `set_halt_req` strobe sets the halted bit (bit 15) at the next clock edge. If a clear request arrives in the same cycle, the set wins.
- R3: The halted bit falls only on a `clr_halt_req` strobe that has no set or stall beside it. CPU writes never change bit 15.
- R4: Bit 3 (unhalt flag) sets when bit 15 goes from 1 to 0. Bit 2 (halt flag) sets when bit 15 goes from 0 to 1. A set request while the endpoint is already halted does not set bit 2 again.
- R5: Bit 4 (end-of-packet flag) sets at the edge that samples each `pkt_done` strobe.
- R6: Bit 5 (end-of-transfer flag) sets when a packet completes with `pkt_zlp` low and `pkt_len` below `cfg_max_len`.
- R7: A packet with `pkt_zlp` high sets bit 5 only if the previous packet was full size (`pkt_len` >= `cfg_max_len`). A short packet or a zero-length packet clears that memory, so a second zero-length packet in a row sets nothing.
- R8: A CPU write with a 1 in any of bits 5..2 clears that flag. Writing 0 leaves a flag as it is, and writes to every other bit are ignored.
- R9: If a hardware event and a CPU clear hit the same flag in the same cycle, the flag ends up set.
- R10: Bit 14 shows `cfg_dir_in` and bit 13 shows `cfg_present`, each one cycle after the input. Bits 12..6 and 1..0 always read 0.
- R11: `nak_force` is 1 exactly when bit 14 is 0 (OUT) and bit 5 is set.
- R12: `irq` is registered and updates at the same edge as the flags. It is the OR over i of flag bit (2+i) AND `irq_en[i]`, so `irq_en[0]` gates halt, [1] unhalt, [2] end-of-packet and [3] end-of-transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pkt_done | input | 1 | Packet sent or received without error |
| pkt_len | input | LEN_W | Byte count of the completed packet |
| pkt_zlp | input | 1 | The completed packet had no data |
| stall_sent | input | 1 | STALL handshake returned to the host |
| set_halt_req | input | 1 | Endpoint-halt set feature request decoded |
| clr_halt_req | input | 1 | Endpoint-halt clear feature request decoded |
| cfg_dir_in | input | 1 | 1 = IN endpoint, 0 = OUT endpoint |
| cfg_present | input | 1 | Endpoint exists in the active configuration |
| cfg_max_len | input | LEN_W | Maximum packet size in bytes |
| irq_en | input | 4 | Enable per interrupt flag (bits 2..5) |
| cpu_wr | input | 1 | CPU write strobe to the status word |
| cpu_wdata | input | 16 | CPU write data, write-1-to-clear |
| status | output | 16 | Status and interrupt word |
| irq | output | 1 | Interrupt request |
| nak_force | output | 1 | Tell the protocol engine to NAK OUT packets |

## Verification
The assertions check on every cycle that halt strobes move bit 15 and that an unhalt or halt transition sets its flag. They also check that each completed packet sets the end-of-packet flag, that a zero write or a clear losing to a set leaves a flag pending, that `nak_force` follows OUT plus a pending end of transfer, and that the unused bits stay zero. Only the bench scenarios show the transfer-end rules, because these depend on packet history: short packets, a zero-length packet after full-size ones, a second zero-length packet in a row, and oversized packets. The bench scenarios are also the only check of the per-bit mapping of the interrupt enables and of the direction and presence timing.

// File: rtl/usb_ep_pkg.sv
package usb_ep_pkg;
  localparam int STAT_W = 16;
  localparam int B_HALT = 15;
  localparam int B_DIR  = 14;
  localparam int B_PRES = 13;
  localparam int INT_LO = 2;
  localparam int N_INT  = 4;
  localparam int INT_HI = INT_LO + N_INT - 1;

  // flag order follows bit order 5..2
  typedef struct packed {
    logic eot;
    logic eop;
    logic unhalt;
    logic halt;
  } ep_flags_t;
endpackage

// File: rtl/ep_halt_tracker.sv
module ep_halt_tracker (
  input  logic clk,
  input  logic rst,
  input  logic stall,
  input  logic set_req,
  input  logic clr_req,
  output logic halt_q,
  output logic rise_ev,
  output logic fall_ev
);
  logic halt_d;

  // a set or stall beats a simultaneous clear
  always_comb begin
    halt_d = halt_q;
    if (stall || set_req)
      halt_d = 1'b1;
    else if (clr_req)
      halt_d = 1'b0;
  end

  assign rise_ev = !halt_q && halt_d;
  assign fall_ev = halt_q && !halt_d;

  always_ff @(posedge clk) begin
    if (rst) halt_q <= 1'b0;
    else     halt_q <= halt_d;
  end
endmodule

// File: rtl/ep_xfer_detect.sv
module ep_xfer_detect #(
  parameter int LEN_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pkt_done,
  input  logic [LEN_W-1:0] pkt_len,
  input  logic             pkt_zlp,
  input  logic [LEN_W-1:0] max_len,
  output logic             eop_ev,
  output logic             eot_ev
);
  logic prev_full_q;
  logic full_pkt;

  assign full_pkt = !pkt_zlp && (pkt_len >= max_len);
  assign eop_ev   = pkt_done;

  always_comb begin
    eot_ev = 1'b0;
    if (pkt_done) begin
      if (pkt_zlp)        eot_ev = prev_full_q;
      else if (!full_pkt) eot_ev = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           prev_full_q <= 1'b0;
    else if (pkt_done) prev_full_q <= full_pkt;
  end
endmodule

// File: rtl/ep_int_reg.sv
module ep_int_reg #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_ev,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] flag_q,
  output logic [N-1:0] flag_d
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    // hardware set has priority over a CPU clear
    assign flag_d[i] = set_ev[i] | (flag_q[i] & ~clr_mask[i]);

    always_ff @(posedge clk) begin
      if (rst) flag_q[i] <= 1'b0;
      else     flag_q[i] <= flag_d[i];
    end
  end
endmodule

// File: rtl/usb_ep_status.sv
module usb_ep_status
  import usb_ep_pkg::*;
#(
  parameter int LEN_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pkt_done,
  input  logic [LEN_W-1:0]  pkt_len,
  input  logic              pkt_zlp,
  input  logic              stall_sent,
  input  logic              set_halt_req,
  input  logic              clr_halt_req,
  input  logic              cfg_dir_in,
  input  logic              cfg_present,
  input  logic [LEN_W-1:0]  cfg_max_len,
  input  logic [N_INT-1:0]  irq_en,
  input  logic              cpu_wr,
  input  logic [STAT_W-1:0] cpu_wdata,
  output logic [STAT_W-1:0] status,
  output logic              irq,
  output logic              nak_force
);
  logic      halt_q, halt_rise, halt_fall;
  logic      eop_ev, eot_ev;
  logic      dir_q, pres_q, irq_q;
  ep_flags_t set_ev, clr_mask, flag_q, flag_d;
  logic      unused_wbits;

  assign unused_wbits = ^{cpu_wdata[STAT_W-1:INT_HI+1], cpu_wdata[INT_LO-1:0]};

  ep_halt_tracker u_halt (
    .clk(clk), .rst(rst), .stall(stall_sent), .set_req(set_halt_req),
    .clr_req(clr_halt_req), .halt_q(halt_q), .rise_ev(halt_rise),
    .fall_ev(halt_fall)
  );

  ep_xfer_detect #(.LEN_W(LEN_W)) u_xfer (
    .clk(clk), .rst(rst), .pkt_done(pkt_done), .pkt_len(pkt_len),
    .pkt_zlp(pkt_zlp), .max_len(cfg_max_len), .eop_ev(eop_ev), .eot_ev(eot_ev)
  );

  always_comb begin
    set_ev.eot    = eot_ev;
    set_ev.eop    = eop_ev;
    set_ev.unhalt = halt_fall;
    set_ev.halt   = halt_rise;
    clr_mask      = cpu_wr ? ep_flags_t'(cpu_wdata[INT_HI:INT_LO]) : '0;
  end

  ep_int_reg #(.N(N_INT)) u_flags (
    .clk(clk), .rst(rst), .set_ev(set_ev), .clr_mask(clr_mask),
    .flag_q(flag_q), .flag_d(flag_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= 1'b0;
      pres_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      dir_q  <= cfg_dir_in;
      pres_q <= cfg_present;
      irq_q  <= |(flag_d & irq_en);
    end
  end

  always_comb begin
    status                = '0;
    status[B_HALT]        = halt_q;
    status[B_DIR]         = dir_q;
    status[B_PRES]        = pres_q;
    status[INT_HI:INT_LO] = flag_q;
  end

  assign irq       = irq_q;
  assign nak_force = !dir_q && flag_q.eot;
endmodule

// File: rtl/usb_ep_status_chk.sv
module usb_ep_status_chk #(
  parameter int LEN_W = 11
) (
  input logic              clk,
  input logic              rst,
  input logic              pkt_done,
  input logic [LEN_W-1:0]  pkt_len,
  input logic              pkt_zlp,
  input logic              stall_sent,
  input logic              set_halt_req,
  input logic              clr_halt_req,
  input logic              cfg_dir_in,
  input logic              cfg_present,
  input logic [LEN_W-1:0]  cfg_max_len,
  input logic [3:0]        irq_en,
  input logic              cpu_wr,
  input logic [15:0]       cpu_wdata,
  input logic [15:0]       status,
  input logic              irq,
  input logic              nak_force
);
  assert_halt_set_R2: assert property (@(posedge clk) disable iff (rst)
    (stall_sent || set_halt_req) |=> status[15]);

  assert_halt_clr_R3: assert property (@(posedge clk) disable iff (rst)
    (clr_halt_req && !stall_sent && !set_halt_req) |=> !status[15]);

  assert_halt_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!clr_halt_req && !stall_sent && !set_halt_req) |=> $stable(status[15]));

  assert_unhalt_flag_R4: assert property (@(posedge clk) disable iff (rst)
    (status[15] && clr_halt_req && !stall_sent && !set_halt_req) |=> status[3]);

  assert_halt_flag_R4: assert property (@(posedge clk) disable iff (rst)
    (!status[15] && (stall_sent || set_halt_req)) |=> status[2]);

  assert_eop_R5: assert property (@(posedge clk) disable iff (rst)
    pkt_done |=> status[4]);

  assert_zero_write_R8: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && cpu_wdata[5:2] == 4'b0 && status[5]) |=> status[5]);

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
    (pkt_done && cpu_wr && cpu_wdata[4]) |=> status[4]);

  assert_zero_bits_R10: assert property (@(posedge clk) disable iff (rst)
    status[12:6] == 7'b0 && status[1:0] == 2'b0);

  assert_nak_R11: assert property (@(posedge clk) disable iff (rst)
    (!status[14] && status[5]) |-> nak_force);

  assert_irq_mask_R12: assert property (@(posedge clk) disable iff (rst)
    (irq_en == 4'b0) |=> !irq);
endmodule

bind usb_ep_status usb_ep_status_chk #(.LEN_W(LEN_W)) u_chk (.*);

// File: tb/test_usb_ep_status.sv
module test_usb_ep_status;
  localparam int LEN_W = 11;

  logic             clk = 1'b0;
  logic             rst;
  logic             pkt_done, pkt_zlp, stall_sent, set_halt_req, clr_halt_req;
  logic [LEN_W-1:0] pkt_len, cfg_max_len;
  logic             cfg_dir_in, cfg_present, cpu_wr;
  logic [3:0]       irq_en;
  logic [15:0]      cpu_wdata, status;
  logic             irq, nak_force;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  usb_ep_status #(.LEN_W(LEN_W)) i_usb_ep_status (
    .clk(clk), .rst(rst), .pkt_done(pkt_done), .pkt_len(pkt_len),
    .pkt_zlp(pkt_zlp), .stall_sent(stall_sent), .set_halt_req(set_halt_req),
    .clr_halt_req(clr_halt_req), .cfg_dir_in(cfg_dir_in),
    .cfg_present(cfg_present), .cfg_max_len(cfg_max_len), .irq_en(irq_en),
    .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .status(status), .irq(irq),
    .nak_force(nak_force)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pkt(input int len, input logic zlp);
    pkt_done = 1'b1; pkt_len = LEN_W'(len); pkt_zlp = zlp;
    @(negedge clk);
    pkt_done = 1'b0; pkt_zlp = 1'b0; pkt_len = '0;
  endtask

  task automatic wr(input logic [15:0] d);
    cpu_wr = 1'b1; cpu_wdata = d;
    @(negedge clk);
    cpu_wr = 1'b0; cpu_wdata = '0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 status", status, 16'h0000);
    chk("R1 irq/nak", {14'b0, irq, nak_force}, 16'h0000);
  endtask

  task automatic t_halt();
    stall_sent = 1'b1; @(negedge clk); stall_sent = 1'b0;
    chk("R2 R4 stall halts", status & 16'h800C, 16'h8004);
    wr(16'h0004);
    set_halt_req = 1'b1; @(negedge clk); set_halt_req = 1'b0;
    chk("R4 no repeat halt flag", status & 16'h800C, 16'h8000);
    wr(16'hFFFF);
    chk("R3 write keeps halt", status & 16'h8000, 16'h8000);
    clr_halt_req = 1'b1; @(negedge clk); clr_halt_req = 1'b0;
    chk("R3 R4 clear unhalts", status & 16'h800C, 16'h0008);
    wr(16'h0008);
    set_halt_req = 1'b1; clr_halt_req = 1'b1; @(negedge clk);
    set_halt_req = 1'b0; clr_halt_req = 1'b0;
    chk("R2 set beats clear", status & 16'h800C, 16'h8004);
    clr_halt_req = 1'b1; @(negedge clk); clr_halt_req = 1'b0;
    wr(16'h003C);
    chk("R8 all flags cleared", status, 16'h0000);
  endtask

  task automatic t_packets();
    pkt(64, 1'b0);
    chk("R5 full packet eop only", status & 16'h0030, 16'h0010);
    wr(16'h0030);
    pkt(0, 1'b1);
    chk("R7 zlp after full ends", status & 16'h0030, 16'h0030);
    wr(16'h0030);
    pkt(0, 1'b1);
    chk("R7 second zlp no eot", status & 16'h0030, 16'h0010);
    wr(16'h0030);
    pkt(10, 1'b0);
    chk("R6 short packet ends", status & 16'h0030, 16'h0030);
    wr(16'h0030);
    pkt(0, 1'b1);
    chk("R7 zlp after short no eot", status & 16'h0030, 16'h0010);
    wr(16'h0030);
    pkt(100, 1'b0);
    pkt(0, 1'b1);
    chk("R7 oversize counts full", status & 16'h0030, 16'h0030);
    wr(16'h0030);
  endtask

  task automatic t_w1c();
    pkt(5, 1'b0);
    wr(16'h0000);
    chk("R8 zero write no effect", status & 16'h0030, 16'h0030);
    wr(16'h0010);
    chk("R8 clear eop only", status & 16'h0030, 16'h0020);
    wr(16'hFFC3);
    chk("R8 other bits ignored", status & 16'h0030, 16'h0020);
    wr(16'h0020);
    pkt_done = 1'b1; pkt_len = LEN_W'(64); cpu_wr = 1'b1; cpu_wdata = 16'h0010;
    @(negedge clk);
    pkt_done = 1'b0; cpu_wr = 1'b0; cpu_wdata = '0;
    chk("R9 set beats clear", status & 16'h0010, 16'h0010);
    wr(16'h003C);
  endtask

  task automatic t_cfg_nak();
    cfg_dir_in = 1'b1; cfg_present = 1'b1;
    @(negedge clk);
    chk("R10 dir and present", status, 16'h6000);
    pkt(3, 1'b0);
    chk("R11 IN no nak", {15'b0, nak_force}, 16'h0000);
    cfg_dir_in = 1'b0;
    @(negedge clk);
    chk("R11 OUT eot nak", {15'b0, nak_force}, 16'h0001);
    chk("R10 reserved zero", status & 16'h1FC3, 16'h0000);
    wr(16'h0020);
    chk("R11 cleared no nak", {15'b0, nak_force}, 16'h0000);
    wr(16'h003C);
  endtask

  task automatic t_irq();
    irq_en = 4'b0000;
    pkt(64, 1'b0);
    chk("R12 masked", {15'b0, irq}, 16'h0000);
    irq_en = 4'b0010;
    @(negedge clk);
    chk("R12 unhalt enable only", {15'b0, irq}, 16'h0000);
    irq_en = 4'b0100;
    @(negedge clk);
    chk("R12 eop enabled", {15'b0, irq}, 16'h0001);
    wr(16'h0010);
    chk("R12 drops on clear", {15'b0, irq}, 16'h0000);
    irq_en = 4'b0001;
    stall_sent = 1'b1; @(negedge clk); stall_sent = 1'b0;
    chk("R12 halt flag irq", {15'b0, irq}, 16'h0001);
  endtask

  initial begin
    rst = 1'b1; pkt_done = 1'b0; pkt_len = '0; pkt_zlp = 1'b0;
    stall_sent = 1'b0; set_halt_req = 1'b0; clr_halt_req = 1'b0;
    cfg_dir_in = 1'b0; cfg_present = 1'b0; cfg_max_len = LEN_W'(64);
    irq_en = 4'b0; cpu_wr = 1'b0; cpu_wdata = '0;
    @(negedge clk);
    t_reset();
    t_halt();
    t_packets();
    t_w1c();
    t_cfg_nak();
    t_irq();
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=running expected=finished");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule